// File: doc/BRIEF.md
# Interrupt Enable and Pending Controller

This block holds the interrupt enable register for a group of on-chip peripherals and keeps one pending flag per interrupt event. The peripherals are a high-speed serial port (block done, receive full), an incoming and an outgoing host mailbox, a UART (transmit, receive), a GPIO bank and two timers. Each peripheral delivers a one-cycle event pulse. The block records the pulse as a pending flag, gates the flag with the matching enable bit and drives one registered request line per enable group. Software reaches the block over a simple synchronous register bus. It reads and writes the enable word at one address and clears pending flags at a second address by writing ones.

The enable groups do not all behave alike. Some enable bits cover two events. For the GPIO group and the two timer groups, a zero enable bit flushes the pending state and blocks new events. The serial, mailbox and UART groups keep recording events while disabled, and they raise their request as soon as they are enabled again.

Top module: `irq_enable_ctrl`

## Requirements
- R1: After reset the enable register, every pending flag, `irq_o` and `bus_rdata_o` are all zero.
- R2: The enable register sits at address `EN_ADDR` (default 0). Its bits are: bit 0 timer 0, bit 1 timer 1, bit 2 GPIO, bit 3 UART, bit 5 outgoing mailbox, bit 6 incoming mailbox, and bit 7 serial port. A value of 1 enables the group. A read returns the value on `bus_rdata_o` on the clock edge that accepts the read, and the value stays there until the next read.
- R3: Enable bits 15:8 and 4 read back as 0, whatever value is written to them.
- R4: Each `src_ev_i` pulse sets one pending flag. The bits are: 0 timer 0, 1 timer 1, 2 GPIO, 3 UART transmit, 4 UART receive, 5 outgoing mailbox, 6 incoming mailbox, 7 serial block done, and 8 serial receive full. The flags read at address `PEND_ADDR` (default 1) at the same bit positions, and bits 15:9 read as 0.
- R5: Writing to `PEND_ADDR` clears every pending flag whose data bit is 1. Flags whose data bit is 0 are left unchanged.
- R6: If an event and a clear hit the same flag in the same cycle, the flag ends up set.
- R7: When the enable bit of the GPIO group, the timer 1 group or the timer 0 group is 0, that group's pending flag is cleared, and events for that group are ignored.
- R8: The serial, mailbox and UART flags are set by events and kept while their enable bit is 0. Setting the enable bit later raises the request.
- R9: The `irq_o` bits are: 0 timer 0, 1 timer 1, 2 GPIO, 3 UART, 4 outgoing mailbox, 5 incoming mailbox, 6 serial port. Each bit is the registered OR of its group's pending flags, gated by the group's enable bit. It changes on the same edge as the flags and the enable bit.
- R10: A write to any other address changes nothing. A read from any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data, registered |
| src_ev_i | input | 9 | Per-event pulses from the peripherals |
| irq_o | output | 7 | Per-group request lines |

## Verification
The hardest case to reach is a peripheral event and a software clear landing on the same flag in the same cycle. The bench gets there by driving the event pulse and the clearing write on the same falling edge, then reading the flag back. A second hard case is an event that arrives while its group is disabled. The bench disables groups first, sends events to both flushing and non-flushing groups, and only then re-enables them. This shows which flags survived through the status read and the request lines.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int REG_W  = 16;
    localparam int NSRC   = 9;
    localparam int NGRP   = 7;
    localparam logic [REG_W-1:0] EN_MASK = 16'h00EF;

    // Enable bit that gates group g: groups 0..3 use bits 0..3, the others skip bit 4
    function automatic int grp_en_bit(int g);
        return (g < 4) ? g : g + 1;
    endfunction

    // Group that owns pending source s
    function automatic int src_grp(int s);
        if (s <= 3)      return s;
        else if (s == 4) return 3;
        else if (s <= 6) return s - 1;
        else             return 6;
    endfunction

    // Groups 0..2 (timer 0, timer 1, GPIO) flush their pending state when disabled
    function automatic bit grp_flush(int g);
        return g < 3;
    endfunction

    typedef enum logic [1:0] {RD_NONE, RD_EN, RD_PEND} rd_sel_e;
endpackage

// File: rtl/irqc_pend_flag.sv
module irqc_pend_flag #(
    parameter bit FLUSH = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic en_d_i,
    input  logic ev_i,
    input  logic clr_i,
    output logic pend_d_o,
    output logic pend_q_o
);
    logic pend_d, pend_q;

    always_comb begin
        pend_d = ev_i | (pend_q & ~clr_i);
        if (FLUSH) pend_d = pend_d & en_d_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pend_q <= 1'b0;
        else         pend_q <= pend_d;
    end

    assign pend_d_o = pend_d;
    assign pend_q_o = pend_q;
endmodule

// File: rtl/irqc_bus_dec.sv
module irqc_bus_dec import irqc_pkg::*; #(
    parameter int ADDR_W    = 4,
    parameter int EN_ADDR   = 0,
    parameter int PEND_ADDR = 1
) (
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic [REG_W-1:0]  en_q_i,
    output logic [REG_W-1:0]  en_d_o,
    output logic [NSRC-1:0]   clr_o,
    output logic              rd_o,
    output rd_sel_e           rd_sel_o
);
    logic hit_en, hit_pend;

    always_comb begin
        hit_en   = (addr_i == ADDR_W'(EN_ADDR));
        hit_pend = (addr_i == ADDR_W'(PEND_ADDR));
        en_d_o   = (sel_i && wr_i && hit_en) ? (wdata_i & EN_MASK) : en_q_i;
        clr_o    = (sel_i && wr_i && hit_pend) ? wdata_i[NSRC-1:0] : '0;
        rd_o     = sel_i && !wr_i;
        if (hit_en)        rd_sel_o = RD_EN;
        else if (hit_pend) rd_sel_o = RD_PEND;
        else               rd_sel_o = RD_NONE;
    end
endmodule

// File: rtl/irqc_grp_or.sv
module irqc_grp_or import irqc_pkg::*; (
    input  logic [NSRC-1:0] pend_i,
    input  logic [NGRP-1:0] grp_en_i,
    output logic [NGRP-1:0] req_o
);
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        logic [NSRC-1:0] member;
        for (genvar s = 0; s < NSRC; s++) begin : g_mem
            assign member[s] = (src_grp(s) == g) ? pend_i[s] : 1'b0;
        end
        assign req_o[g] = grp_en_i[g] & (|member);
    end
endmodule

// File: rtl/irq_enable_ctrl.sv
module irq_enable_ctrl import irqc_pkg::*; #(
    parameter int ADDR_W    = 4,
    parameter int EN_ADDR   = 0,
    parameter int PEND_ADDR = 1
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [REG_W-1:0]  bus_wdata_i,
    output logic [REG_W-1:0]  bus_rdata_o,
    input  logic [NSRC-1:0]   src_ev_i,
    output logic [NGRP-1:0]   irq_o
);
    typedef struct packed {
        logic [REG_W-1:0] en;
        logic [REG_W-1:0] rdata;
        logic [NGRP-1:0]  irq;
    } state_t;

    state_t st_d, st_q;

    logic [REG_W-1:0] en_d;
    logic [NSRC-1:0]  clr;
    logic             rd;
    rd_sel_e          rd_sel;
    logic [NGRP-1:0]  grp_en_d;
    logic [NSRC-1:0]  pend_d, pend_q;
    logic [NGRP-1:0]  irq_d;

    irqc_bus_dec #(
        .ADDR_W(ADDR_W), .EN_ADDR(EN_ADDR), .PEND_ADDR(PEND_ADDR)
    ) u_dec (
        .sel_i(bus_sel_i), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
        .wdata_i(bus_wdata_i), .en_q_i(st_q.en), .en_d_o(en_d),
        .clr_o(clr), .rd_o(rd), .rd_sel_o(rd_sel)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_gen
        assign grp_en_d[g] = en_d[grp_en_bit(g)];
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        irqc_pend_flag #(.FLUSH(grp_flush(src_grp(s)))) u_flag (
            .clk_i(clk_i), .rst_ni(rst_ni),
            .en_d_i(grp_en_d[src_grp(s)]), .ev_i(src_ev_i[s]),
            .clr_i(clr[s]), .pend_d_o(pend_d[s]), .pend_q_o(pend_q[s])
        );
    end

    irqc_grp_or u_or (.pend_i(pend_d), .grp_en_i(grp_en_d), .req_o(irq_d));

    always_comb begin
        st_d     = st_q;
        st_d.en  = en_d;
        st_d.irq = irq_d;
        if (rd) begin
            unique case (rd_sel)
                RD_EN:   st_d.rdata = st_q.en;
                RD_PEND: st_d.rdata = REG_W'(pend_q);
                default: st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign bus_rdata_o = st_q.rdata;
    assign irq_o       = st_q.irq;
endmodule

module irq_enable_ctrl_chk import irqc_pkg::*; #(
    parameter int ADDR_W    = 4,
    parameter int EN_ADDR   = 0,
    parameter int PEND_ADDR = 1
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              bus_sel_i,
    input logic              bus_wr_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [REG_W-1:0]  bus_wdata_i,
    input logic [REG_W-1:0]  bus_rdata_o,
    input logic [NSRC-1:0]   src_ev_i,
    input logic [NGRP-1:0]   irq_o,
    input logic [REG_W-1:0]  en_q,
    input logic [NSRC-1:0]   pend_q
);
    logic pend_wr;
    assign pend_wr = bus_sel_i && bus_wr_i && (bus_addr_i == ADDR_W'(PEND_ADDR));

    AST_EN_RSVD_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_sel_i && !bus_wr_i && bus_addr_i == ADDR_W'(EN_ADDR)) |=> ((bus_rdata_o & ~EN_MASK) == '0)); // R3
    AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_wr && bus_wdata_i[5] && !src_ev_i[5]) |=> !pend_q[5]); // R5
    AST_EVENT_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        src_ev_i[6] |=> pend_q[6]); // R6
    AST_FLUSH_GPIO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_q[2] |-> !pend_q[2]); // R7
    AST_FLUSH_TMR0: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_q[0] |-> !pend_q[0]); // R7
    AST_HOLD_DISABLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_q[7] && !(pend_wr && bus_wdata_i[7])) |=> pend_q[7]); // R8
    AST_IRQ_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_q[3] |-> !irq_o[3]); // R9
    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o[0] |-> pend_q[0]); // R9
endmodule

bind irq_enable_ctrl irq_enable_ctrl_chk #(
    .ADDR_W(ADDR_W), .EN_ADDR(EN_ADDR), .PEND_ADDR(PEND_ADDR)
) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .src_ev_i(src_ev_i), .irq_o(irq_o), .en_q(st_q.en), .pend_q(pend_q)
);

// File: tb/irq_enable_ctrl_tb.sv
module irq_enable_ctrl_tb;
    localparam time HALF = 4ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel = 1'b0, wr = 1'b0;
    logic [3:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic [8:0]  ev = '0;
    logic [6:0]  irq;

    int checks = 0, failures = 0;
    bit done = 1'b0;

    always #HALF clk = ~clk;

    irq_enable_ctrl u_dut (
        .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .src_ev_i(ev), .irq_o(irq)
    );

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(logic [3:0] a, logic [15:0] d, logic [8:0] e = '0);
        @(negedge clk); sel = 1; wr = 1; addr = a; wdata = d; ev = e;
        @(negedge clk); sel = 0; wr = 0; ev = '0;
    endtask

    task automatic bus_read(logic [3:0] a, output logic [15:0] d);
        @(negedge clk); sel = 1; wr = 0; addr = a;
        @(negedge clk); sel = 0; d = rdata;
    endtask

    task automatic pulse(logic [8:0] e);
        @(negedge clk); ev = e;
        @(negedge clk); ev = '0;
    endtask

    task automatic t_reset();
        logic [15:0] d;
        chk("R1 irq", 16'(irq), 16'h0);
        chk("R1 rdata", rdata, 16'h0);
        bus_read(4'd0, d); chk("R1 enable", d, 16'h0);
        bus_read(4'd1, d); chk("R1 pending", d, 16'h0);
    endtask

    task automatic t_enable_rw();
        logic [15:0] d;
        bus_write(4'd0, 16'hFFFF);
        bus_read(4'd0, d); chk("R3 reserved bits zero", d, 16'h00EF);
        bus_write(4'd0, 16'h0025);
        bus_read(4'd0, d); chk("R2 enable readback", d, 16'h0025);
        chk("R2 rdata held", rdata, 16'h0025);
        chk("R9 no pending no irq", 16'(irq), 16'h0);
    endtask

    task automatic t_pend_clear();
        logic [15:0] d;
        bus_write(4'd0, 16'h00EF);
        pulse(9'h1FF);
        chk("R9 all groups request", 16'(irq), 16'h007F);
        bus_read(4'd1, d); chk("R4 all flags", d, 16'h01FF);
        bus_write(4'd1, 16'h0008);
        bus_read(4'd1, d); chk("R5 clear uart tx only", d, 16'h01F7);
        chk("R9 uart held by rx", 16'(irq[3]), 16'h1);
        bus_write(4'd1, 16'h0010);
        chk("R9 uart dropped", 16'(irq), 16'h0077);
        bus_write(4'd1, 16'hFFFF);
        bus_read(4'd1, d); chk("R5 clear all", d, 16'h0);
        chk("R5 irq cleared", 16'(irq), 16'h0);
    endtask

    task automatic t_race();
        logic [15:0] d;
        bus_write(4'd0, 16'h00EF);
        pulse(9'h020);
        bus_write(4'd1, 16'h0060, 9'h040);
        bus_read(4'd1, d); chk("R6 event wins over clear", d, 16'h0040);
        chk("R6 irq mailbox in", 16'(irq), 16'h0020);
        bus_write(4'd1, 16'hFFFF);
    endtask

    task automatic t_flush();
        logic [15:0] d;
        bus_write(4'd0, 16'h00EF);
        pulse(9'h007);
        chk("R9 gpio timers request", 16'(irq), 16'h0007);
        bus_write(4'd0, 16'h00E8);
        bus_read(4'd1, d); chk("R7 flush on disable", d, 16'h0);
        chk("R7 irq dropped", 16'(irq), 16'h0);
        pulse(9'h007);
        bus_write(4'd0, 16'h00EF);
        bus_read(4'd1, d); chk("R7 events ignored while off", d, 16'h0);
        chk("R7 no irq after enable", 16'(irq), 16'h0);
    endtask

    task automatic t_hold();
        logic [15:0] d;
        bus_write(4'd0, 16'h0000);
        pulse(9'h0D0);
        chk("R8 no irq while disabled", 16'(irq), 16'h0);
        bus_read(4'd1, d); chk("R8 flags kept", d, 16'h00D0);
        bus_write(4'd0, 16'h00EF);
        chk("R8 irq on enable", 16'(irq), 16'h0068);
        bus_write(4'd1, 16'hFFFF);
    endtask

    task automatic t_unmapped();
        logic [15:0] d;
        bus_write(4'd0, 16'h0003);
        bus_write(4'd5, 16'h00FF);
        bus_read(4'd0, d); chk("R10 write elsewhere ignored", d, 16'h0003);
        bus_read(4'd9, d); chk("R10 read elsewhere zero", d, 16'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enable_rw();
        t_pend_clear();
        t_race();
        t_flush();
        t_hold();
        t_unmapped();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; failures++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule